// File: doc/BRIEF.md
# Serial Bus Condition Timers

This block turns the START and STOP events of a two-wire serial bus into four status flags. Another block detects the bus conditions and sends one-cycle pulses here. From these pulses the block derives a busy flag and measures the time since the most recent STOP, in clock cycles. It then compares that time with three thresholds that software writes. The free, available and idle flags each have their own threshold, so software may give them any order; for example, idle may be configured to come before available.

A START or an entry into the high-data-rate mode stops the measurement and clears the three time-based flags. Only a later STOP restarts the count. The elapsed counter saturates, so a bus that stays quiet for a long time keeps its flags. A typical idle threshold is the cycle count for roughly 200 microseconds at the clock rate of the system. The block has no data path, so all of its pins are plain control and status signals with no handshake.

Top module: `bus_cond_timers`

## Requirements
- R1: After reset, bus_busy, bus_free, bus_available and bus_idle are all low. The three time-based flags stay low for as long as no STOP pulse arrives.
- R2: A STOP pulse that is captured on a clock edge, with no START or HDR pulse in the same cycle, drives bus_busy low from that edge onward. It also restarts the elapsed count at zero.
- R3: A START pulse drives bus_busy high and bus_free, bus_available and bus_idle low from the next edge onward. Counting stays halted until the next STOP.
- R4: Each time-based flag is high exactly when the bus is counting and at least as many edges have passed since the STOP edge as its own threshold. The three flags are evaluated independently, and any ordering of the thresholds is legal.
- R5: A threshold of zero raises its flag in the same cycle in which the STOP is captured.
- R6: An HDR-entry pulse clears the three time-based flags, drives bus_busy high and halts counting. After that, only a STOP restarts the timing.
- R7: Pulses that coincide are resolved in priority order: HDR entry first, then START, then STOP.
- R8: The elapsed count saturates at its maximum value. A flag that has asserted therefore stays high for as long as the bus remains quiet.
- R9: bus_busy is never high while any of bus_free, bus_available or bus_idle is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pulse | input | 1 | One-cycle START detection |
| stop_pulse | input | 1 | One-cycle STOP detection |
| hdr_entry | input | 1 | One-cycle HDR mode entry indication |
| free_thresh | input | W (32) | Cycles from STOP to bus_free |
| avail_thresh | input | W (32) | Cycles from STOP to bus_available |
| idle_thresh | input | W (32) | Cycles from STOP to bus_idle |
| bus_busy | output | 1 | Bus in use |
| bus_free | output | 1 | Free time elapsed |
| bus_available | output | 1 | Available time elapsed |
| bus_idle | output | 1 | Idle time elapsed |

## Verification
The bench probes each threshold one cycle before and exactly at its count. An off-by-one comparison would move a flag edge by one cycle and fail one of those two samples. It also uses orderings in which available or idle comes before free, which catches a design that chains one flag on another. A 4-bit instance is run past its counter wrap: a design whose counter wraps instead of saturating drops idle on a quiet bus. Further cases cover HDR entry, a START coinciding with a STOP, and a long stretch without any STOP. A design that counts without a STOP, or that lets STOP win over START, would raise flags that should stay low.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum int unsigned {
    FLG_FREE  = 0,
    FLG_AVAIL = 1,
    FLG_IDLE  = 2
  } flag_e;
  localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/bct_elapsed.sv
// Saturating elapsed-cycle counter; runs only between a STOP and the next halt.
module bct_elapsed #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic         restart,
  output logic         running,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (halt) begin
      running <= 1'b0;
      count   <= '0;
    end else if (restart) begin
      running <= 1'b1;
      count   <= '0;
    end else if (running && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bct_thresh_cmp.sv
module bct_thresh_cmp #(
  parameter int unsigned W = 32
) (
  input  logic         running,
  input  logic [W-1:0] count,
  input  logic [W-1:0] thresh,
  output logic         hit
);
  always_comb hit = running && (count >= thresh);
endmodule

// File: rtl/bct_busy_track.sv
module bct_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic stop_ev,
  input  logic hdr_ev,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy <= 1'b0;
    else if (hdr_ev || start_ev) busy <= 1'b1;
    else if (stop_ev)            busy <= 1'b0;
  end
endmodule

// File: rtl/bus_cond_timers.sv
module bus_cond_timers #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_pulse,
  input  logic         stop_pulse,
  input  logic         hdr_entry,
  input  logic [W-1:0] free_thresh,
  input  logic [W-1:0] avail_thresh,
  input  logic [W-1:0] idle_thresh,
  output logic         bus_busy,
  output logic         bus_free,
  output logic         bus_available,
  output logic         bus_idle
);
  import bct_pkg::*;

  logic                          running;
  logic [W-1:0]                  count;
  logic [NUM_FLAGS-1:0][W-1:0]   thr;
  logic [NUM_FLAGS-1:0]          hit;

  always_comb begin
    thr[FLG_FREE]  = free_thresh;
    thr[FLG_AVAIL] = avail_thresh;
    thr[FLG_IDLE]  = idle_thresh;
  end

  // HDR entry and START both halt timing; STOP restarts it (lowest priority).
  bct_elapsed #(.W(W)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt    (hdr_entry | start_pulse),
    .restart (stop_pulse),
    .running (running),
    .count   (count)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cmp
    bct_thresh_cmp #(.W(W)) u_cmp (
      .running (running),
      .count   (count),
      .thresh  (thr[g]),
      .hit     (hit[g])
    );
  end

  bct_busy_track u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_pulse),
    .stop_ev  (stop_pulse),
    .hdr_ev   (hdr_entry),
    .busy     (bus_busy)
  );

  assign bus_free      = hit[FLG_FREE];
  assign bus_available = hit[FLG_AVAIL];
  assign bus_idle      = hit[FLG_IDLE];
endmodule

// File: rtl/bct_checker.sv
module bct_checker (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic stop_pulse,
  input logic hdr_entry,
  input logic bus_busy,
  input logic bus_free,
  input logic bus_available,
  input logic bus_idle
);
  logic any_flag;
  assign any_flag = bus_free | bus_available | bus_idle;

  assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !start_pulse && !hdr_entry) |=> !bus_busy);

  assert_start_clears_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (bus_busy && !any_flag));

  assert_hdr_clears_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_entry |=> (bus_busy && !any_flag));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && !start_pulse && !hdr_entry && !stop_pulse) |=> bus_idle);

  assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !any_flag);

  // R1: with reset held, every output is low
  always @(negedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!bus_busy && !any_flag);
endmodule

bind bus_cond_timers bct_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_pulse   (start_pulse),
  .stop_pulse    (stop_pulse),
  .hdr_entry     (hdr_entry),
  .bus_busy      (bus_busy),
  .bus_free      (bus_free),
  .bus_available (bus_available),
  .bus_idle      (bus_idle)
);

// File: tb/sim_bus_cond_timers.sv
module sim_bus_cond_timers;
  localparam int CLK_P = 10;
  localparam int W     = 32;
  localparam int SW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_pulse = 1'b0, stop_pulse = 1'b0, hdr_entry = 1'b0;
  logic [W-1:0]  free_thresh = '0, avail_thresh = '0, idle_thresh = '0;
  logic [SW-1:0] s_free = '0, s_avail = '0, s_idle = '0;
  logic busy, free_f, avail_f, idle_f;
  logic s_busy, s_free_f, s_avail_f, s_idle_f;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_cond_timers #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .hdr_entry(hdr_entry), .free_thresh(free_thresh), .avail_thresh(avail_thresh),
    .idle_thresh(idle_thresh), .bus_busy(busy), .bus_free(free_f),
    .bus_available(avail_f), .bus_idle(idle_f));

  bus_cond_timers #(.W(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .hdr_entry(hdr_entry), .free_thresh(s_free), .avail_thresh(s_avail),
    .idle_thresh(s_idle), .bus_busy(s_busy), .bus_free(s_free_f),
    .bus_available(s_avail_f), .bus_idle(s_idle_f));

  // free, avail, idle thresholds, cycles waited after the STOP edge
  localparam int TBL [8][4] = '{
    '{20, 10, 40, 5},
    '{20, 10, 40, 10},
    '{20, 10, 40, 25},
    '{20, 10, 40, 40},
    '{30, 30,  8, 8},
    '{ 0,  0,  0, 0},
    '{12,  5, 12, 11},
    '{12,  5, 12, 12}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int which); // 0 start, 1 stop, 2 hdr
    @(negedge clk);
    if (which == 0) start_pulse = 1'b1;
    else if (which == 1) stop_pulse = 1'b1;
    else hdr_entry = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0; stop_pulse = 1'b0; hdr_entry = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "idle in reset", idle_f, 1'b0);
    rst_n = 1'b1;
    wait_cyc(60);
    chk("R1", "free without STOP", free_f, 1'b0);
    chk("R1", "avail without STOP", avail_f, 1'b0);
    chk("R1", "idle without STOP", idle_f, 1'b0);
    chk("R1", "busy without START", busy, 1'b0);

    // Table walk: R4 ordering, R5 zero threshold, R2 busy low
    for (int i = 0; i < 8; i++) begin
      pulse(0);
      free_thresh  = TBL[i][0];
      avail_thresh = TBL[i][1];
      idle_thresh  = TBL[i][2];
      pulse(1);
      wait_cyc(TBL[i][3]);
      chk("R4", $sformatf("row %0d free", i),  free_f,  TBL[i][3] >= TBL[i][0]);
      chk("R4", $sformatf("row %0d avail", i), avail_f, TBL[i][3] >= TBL[i][1]);
      chk("R4", $sformatf("row %0d idle", i),  idle_f,  TBL[i][3] >= TBL[i][2]);
      chk("R2", $sformatf("row %0d busy", i),  busy, 1'b0);
    end

    // R5: zero threshold is visible right at the STOP edge
    pulse(0);
    free_thresh = 0; avail_thresh = 50; idle_thresh = 50;
    pulse(1);
    chk("R5", "free at STOP edge", free_f, 1'b1);
    chk("R5", "avail not yet", avail_f, 1'b0);

    // R3: START drops idle and raises busy
    idle_thresh = 3;
    wait_cyc(5);
    chk("R3", "idle before START", idle_f, 1'b1);
    pulse(0);
    chk("R3", "idle after START", idle_f, 1'b0);
    chk("R3", "free after START", free_f, 1'b0);
    chk("R3", "busy after START", busy, 1'b1);
    wait_cyc(60);
    chk("R3", "idle stays low until STOP", idle_f, 1'b0);

    // R6: HDR entry clears and halts timing; STOP then re-arms free
    free_thresh = 6; avail_thresh = 6; idle_thresh = 6;
    pulse(1);
    wait_cyc(8);
    chk("R6", "free before HDR", free_f, 1'b1);
    pulse(2);
    chk("R6", "free after HDR", free_f, 1'b0);
    chk("R6", "busy after HDR", busy, 1'b1);
    wait_cyc(40);
    chk("R6", "idle stays low in HDR", idle_f, 1'b0);
    pulse(1);
    wait_cyc(5);
    chk("R6", "free one short after STOP", free_f, 1'b0);
    wait_cyc(1);
    chk("R6", "free after HDR exit STOP", free_f, 1'b1);

    // R7: START coincident with STOP wins
    @(negedge clk); start_pulse = 1'b1; stop_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0; stop_pulse = 1'b0;
    wait_cyc(10);
    chk("R7", "busy with START+STOP", busy, 1'b1);
    chk("R7", "free with START+STOP", free_f, 1'b0);
    // R7: HDR coincident with STOP wins
    pulse(1);
    @(negedge clk); hdr_entry = 1'b1; stop_pulse = 1'b1;
    @(negedge clk); hdr_entry = 1'b0; stop_pulse = 1'b0;
    wait_cyc(10);
    chk("R7", "idle with HDR+STOP", idle_f, 1'b0);

    // R8: 4-bit instance saturates instead of wrapping
    s_free = 4'd15; s_avail = 4'd2; s_idle = 4'd15;
    pulse(1);
    wait_cyc(15);
    chk("R8", "narrow idle at max", s_idle_f, 1'b1);
    wait_cyc(30);
    chk("R8", "narrow idle past wrap", s_idle_f, 1'b1);
    chk("R8", "narrow free past wrap", s_free_f, 1'b1);
    chk("R9", "narrow busy low with flags", s_busy, 1'b0);

    // R9: busy and flags never coexist after START
    pulse(0);
    chk("R9", "narrow flags after START", s_avail_f | s_idle_f | s_free_f, 1'b0);
    chk("R9", "narrow busy after START", s_busy, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule